// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block is the purely combinational execute stage of a 32-bit load/store RISC core. Each cycle it receives the primary opcode, the function code, the 5-bit shift-amount field, the 16-bit immediate field and the two source operands read from the register file: `src_a_i` from the rs port and `src_b_i` from the rt port. It returns the value to be written back, a write enable for the destination register, an overflow-exception flag and a reserved-instruction flag.

Inside the block, a decoder sorts the instruction into one operation kind. The kinds are add, subtract, signed set-less-than, unsigned set-less-than, and, or, xor, nor, shift left, logical shift right, arithmetic shift right and load-upper. The decoder also sets how the immediate is extended, where the shift amount comes from, and whether signed overflow traps. The block holds no state. The enclosing pipeline registers the outputs and routes the two exception flags to its trap logic.

Top module: `risc_exec_unit`

## Requirements
- R1: With opcode 0x00, function codes 0x20 (trapping add), 0x21 (wrapping add), 0x22 (trapping subtract) and 0x23 (wrapping subtract) produce `src_a_i + src_b_i` or `src_a_i - src_b_i` modulo 2^32.
- R2: With opcode 0x00, function codes 0x24, 0x25, 0x26 and 0x27 produce the bitwise AND, OR, XOR and NOR of the two operands.
- R3: A signed overflow on function codes 0x20 or 0x22, or on opcode 0x08, sets `ovf_exc_o` and clears `wr_en_o`. Function codes 0x21 and 0x23 and opcode 0x09 never set `ovf_exc_o`, even when the signed sum overflows.
- R4: With opcode 0x00, function codes 0x00, 0x02 and 0x03 shift `src_b_i` by `shamt_i`. Code 0x00 shifts left, 0x02 shifts right filling with zeros, and 0x03 shifts right filling with copies of bit 31.
- R5: Function codes 0x04, 0x06 and 0x07 perform the same three shifts. The amount is taken from bits [4:0] of `src_a_i`, and the upper bits of `src_a_i` have no effect.
- R6: Function codes 0x2a and 0x2b, and opcodes 0x0a and 0x0b, produce 1 or 0. The first of each pair compares signed and the second compares unsigned, so operands 1 and 0xffffffff give 0 when signed and 1 when unsigned.
- R7: Opcodes 0x08, 0x09, 0x0a and 0x0b sign-extend the immediate. Opcodes 0x0c, 0x0d and 0x0e zero-extend it and apply AND, OR or XOR with `src_a_i`.
- R8: Opcode 0x0f produces the immediate in bits [31:16] with bits [15:0] zero.
- R9: Any other opcode, or opcode 0x00 with any other function code, clears `wr_en_o`, sets `rsvd_exc_o`, clears `ovf_exc_o` and drives a zero result.
- R10: Every recognised instruction that does not overflow sets `wr_en_o` and clears both exception flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function code (register format only) |
| shamt_i | input | 5 | Constant shift amount field |
| imm_i | input | 16 | Immediate field |
| src_a_i | input | 32 | Operand from the rs register |
| src_b_i | input | 32 | Operand from the rt register |
| result_o | output | 32 | Value for the destination register |
| wr_en_o | output | 1 | Destination write enable |
| ovf_exc_o | output | 1 | Signed-overflow exception |
| rsvd_exc_o | output | 1 | Unrecognised instruction |

## Verification
The bench targets the edges of signed overflow: 0x7fffffff plus 1, and 0x80000000 minus 1, in both the trapping and the wrapping forms. A design that checks overflow with unsigned carry, or traps on the wrapping forms, would flag or suppress the wrong writes. It uses negative immediates with the compare forms and high-bit immediates with the logical forms, which catches an extension chosen for the wrong opcode. It checks arithmetic right shifts of negative values, and variable shifts whose amount register has upper bits set, which catches zero fill or an amount that wraps wrongly. Random instructions, including illegal encodings, are compared against a model built from the requirements.

// File: rtl/risc_exec_pkg.sv
package risc_exec_pkg;
    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0a;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0b;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0c;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0d;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0e;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0f;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
    localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
    localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2a;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2b;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_SLT, K_SLTU,
        K_AND, K_OR, K_XOR, K_NOR,
        K_SLL, K_SRL, K_SRA, K_LUI
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     b_is_imm;
        logic     imm_signed;
        logic     amt_from_rs;
        logic     traps_ovf;
        logic     legal;
    } dec_t;
endpackage

// File: rtl/risc_exec_decode.sv
module risc_exec_decode
    import risc_exec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    output dec_t             dec_o
);
    always_comb begin
        dec_o.kind        = K_ADD;
        dec_o.b_is_imm    = 1'b0;
        dec_o.imm_signed  = 1'b0;
        dec_o.amt_from_rs = 1'b0;
        dec_o.traps_ovf   = 1'b0;
        dec_o.legal       = 1'b1;
        unique case (opcode_i)
            OPC_REG: begin
                unique case (funct_i)
                    FN_SLL:  dec_o.kind = K_SLL;
                    FN_SRL:  dec_o.kind = K_SRL;
                    FN_SRA:  dec_o.kind = K_SRA;
                    FN_SLLV: begin dec_o.kind = K_SLL; dec_o.amt_from_rs = 1'b1; end
                    FN_SRLV: begin dec_o.kind = K_SRL; dec_o.amt_from_rs = 1'b1; end
                    FN_SRAV: begin dec_o.kind = K_SRA; dec_o.amt_from_rs = 1'b1; end
                    FN_ADD:  begin dec_o.kind = K_ADD; dec_o.traps_ovf = 1'b1; end
                    FN_ADDU: dec_o.kind = K_ADD;
                    FN_SUB:  begin dec_o.kind = K_SUB; dec_o.traps_ovf = 1'b1; end
                    FN_SUBU: dec_o.kind = K_SUB;
                    FN_AND:  dec_o.kind = K_AND;
                    FN_OR:   dec_o.kind = K_OR;
                    FN_XOR:  dec_o.kind = K_XOR;
                    FN_NOR:  dec_o.kind = K_NOR;
                    FN_SLT:  dec_o.kind = K_SLT;
                    FN_SLTU: dec_o.kind = K_SLTU;
                    default: dec_o.legal = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                dec_o.kind = K_ADD; dec_o.b_is_imm = 1'b1;
                dec_o.imm_signed = 1'b1; dec_o.traps_ovf = 1'b1;
            end
            OPC_ADDIU: begin
                dec_o.kind = K_ADD; dec_o.b_is_imm = 1'b1; dec_o.imm_signed = 1'b1;
            end
            OPC_SLTI: begin
                dec_o.kind = K_SLT; dec_o.b_is_imm = 1'b1; dec_o.imm_signed = 1'b1;
            end
            OPC_SLTIU: begin
                dec_o.kind = K_SLTU; dec_o.b_is_imm = 1'b1; dec_o.imm_signed = 1'b1;
            end
            OPC_ANDI: begin dec_o.kind = K_AND; dec_o.b_is_imm = 1'b1; end
            OPC_ORI:  begin dec_o.kind = K_OR;  dec_o.b_is_imm = 1'b1; end
            OPC_XORI: begin dec_o.kind = K_XOR; dec_o.b_is_imm = 1'b1; end
            OPC_LUI:  dec_o.kind = K_LUI;
            default:  dec_o.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/risc_exec_shifter.sv
module risc_exec_shifter #(
    parameter int XLEN = 32,
    parameter int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [SH_W-1:0] amt_i,
    input  logic            right_i,
    input  logic            arith_i,
    output logic [XLEN-1:0] res_o
);
    // Left shifts reuse the right-shift stages on a bit-reversed word.
    logic [XLEN-1:0] fwd;
    logic [XLEN-1:0] stage [SH_W+1];
    logic            fill;

    assign fill = right_i & arith_i & val_i[XLEN-1];

    for (genvar i = 0; i < XLEN; i++) begin : g_rev_in
        assign fwd[i] = right_i ? val_i[i] : val_i[XLEN-1-i];
    end

    assign stage[0] = fwd;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][XLEN-1:STEP]}
                                     : stage[k];
    end

    for (genvar i = 0; i < XLEN; i++) begin : g_rev_out
        assign res_o[i] = right_i ? stage[SH_W][i] : stage[SH_W][XLEN-1-i];
    end
endmodule

// File: rtl/risc_exec_arith.sv
module risc_exec_arith #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            ovf_o,
    output logic            lt_s_o,
    output logic            lt_u_o
);
    logic [XLEN-1:0] b_eff;

    assign b_eff  = sub_i ? ~b_i : b_i;
    assign sum_o  = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
    // Overflow: like-signed inputs to the adder give a result of the other sign.
    assign ovf_o  = (a_i[XLEN-1] == b_eff[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);
    assign lt_s_o = $signed(a_i) < $signed(b_i);
    assign lt_u_o = a_i < b_i;
endmodule

// File: rtl/risc_exec_unit.sv
module risc_exec_unit
    import risc_exec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = $clog2(XLEN)
) (
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    input  logic [SH_W-1:0]  shamt_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0]  src_a_i,
    input  logic [XLEN-1:0]  src_b_i,
    output logic [XLEN-1:0]  result_o,
    output logic             wr_en_o,
    output logic             ovf_exc_o,
    output logic             rsvd_exc_o
);
    localparam int PAD_W = XLEN - IMM_W;

    dec_t            dec;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opnd_b;
    logic [SH_W-1:0] shift_amt;
    logic [XLEN-1:0] sum;
    logic            ovf_raw;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] shifted;

    risc_exec_decode u_dec (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .dec_o    (dec)
    );

    assign imm_ext   = {{PAD_W{dec.imm_signed & imm_i[IMM_W-1]}}, imm_i};
    assign opnd_b    = dec.b_is_imm ? imm_ext : src_b_i;
    assign shift_amt = dec.amt_from_rs ? src_a_i[SH_W-1:0] : shamt_i;

    risc_exec_arith #(.XLEN(XLEN)) u_arith (
        .a_i    (src_a_i),
        .b_i    (opnd_b),
        .sub_i  (dec.kind == K_SUB),
        .sum_o  (sum),
        .ovf_o  (ovf_raw),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    risc_exec_shifter #(.XLEN(XLEN), .SH_W(SH_W)) u_shift (
        .val_i   (src_b_i),
        .amt_i   (shift_amt),
        .right_i (dec.kind != K_SLL),
        .arith_i (dec.kind == K_SRA),
        .res_o   (shifted)
    );

    always_comb begin
        result_o = '0;
        if (dec.legal) begin
            unique case (dec.kind)
                K_ADD, K_SUB: result_o = sum;
                K_SLT:        result_o = {{(XLEN-1){1'b0}}, lt_s};
                K_SLTU:       result_o = {{(XLEN-1){1'b0}}, lt_u};
                K_AND:        result_o = src_a_i & opnd_b;
                K_OR:         result_o = src_a_i | opnd_b;
                K_XOR:        result_o = src_a_i ^ opnd_b;
                K_NOR:        result_o = ~(src_a_i | opnd_b);
                K_SLL, K_SRL, K_SRA: result_o = shifted;
                K_LUI:        result_o = {imm_i, {PAD_W{1'b0}}};
                default:      result_o = '0;
            endcase
        end
    end

    always_comb begin
        ovf_exc_o  = dec.legal & dec.traps_ovf & ovf_raw;
        wr_en_o    = dec.legal & ~ovf_exc_o;
        rsvd_exc_o = ~dec.legal;
    end
endmodule

// File: rtl/risc_exec_unit_chk.sv
module risc_exec_unit_chk (
    input logic [5:0]  opcode_i,
    input logic [5:0]  funct_i,
    input logic [15:0] imm_i,
    input logic [31:0] result_o,
    input logic        wr_en_o,
    input logic        ovf_exc_o,
    input logic        rsvd_exc_o
);
    logic is_trap_form;
    logic is_set_form;
    assign is_trap_form = (opcode_i == 6'h08) ||
                          (opcode_i == 6'h00 && (funct_i == 6'h20 || funct_i == 6'h22));
    assign is_set_form  = (opcode_i == 6'h0a) || (opcode_i == 6'h0b) ||
                          (opcode_i == 6'h00 && (funct_i == 6'h2a || funct_i == 6'h2b));

    always_comb begin
        assert_no_write_on_ovf_R3: assert (!(ovf_exc_o && wr_en_o))
            else $error("overflow with write enable");
        assert_ovf_only_trapping_R3: assert (!ovf_exc_o || is_trap_form)
            else $error("overflow on non-trapping form");
        assert_set_boolean_R6: assert (!(is_set_form && !rsvd_exc_o) || result_o[31:1] == 31'd0)
            else $error("set-less-than not boolean");
        assert_lui_layout_R8: assert (!(opcode_i == 6'h0f) ||
                                      (result_o[15:0] == 16'd0 && result_o[31:16] == imm_i))
            else $error("load-upper layout wrong");
        assert_rsvd_blocks_R9: assert (!rsvd_exc_o || (!wr_en_o && !ovf_exc_o && result_o == 32'd0))
            else $error("reserved instruction side effect");
        assert_write_default_R10: assert (rsvd_exc_o || ovf_exc_o || wr_en_o)
            else $error("legal instruction not written");
    end
endmodule

bind risc_exec_unit risc_exec_unit_chk u_chk (.*);

// File: tb/risc_exec_unit_bench.sv
module risc_exec_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic [5:0]  opcode;
    logic [5:0]  funct;
    logic [4:0]  shamt;
    logic [15:0] imm;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic [31:0] result;
    logic        wr_en;
    logic        ovf_exc;
    logic        rsvd_exc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    risc_exec_unit u_risc_exec_unit (
        .opcode_i   (opcode),
        .funct_i    (funct),
        .shamt_i    (shamt),
        .imm_i      (imm),
        .src_a_i    (src_a),
        .src_b_i    (src_b),
        .result_o   (result),
        .wr_en_o    (wr_en),
        .ovf_exc_o  (ovf_exc),
        .rsvd_exc_o (rsvd_exc)
    );

    // Reference model from the requirements: {rsvd, ovf, we, result}
    function automatic logic [34:0] model(input logic [5:0] op, input logic [5:0] fn,
                                          input logic [4:0] sa, input logic [15:0] im,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] se, ze, r;
        logic        ov, trap, ok;
        se = {{16{im[15]}}, im};
        ze = {16'd0, im};
        r = 32'd0; ov = 1'b0; trap = 1'b0; ok = 1'b1;
        if (op == 6'h00) begin
            case (fn)
                6'h00: r = b << sa;
                6'h02: r = b >> sa;
                6'h03: r = $unsigned($signed(b) >>> sa);
                6'h04: r = b << a[4:0];
                6'h06: r = b >> a[4:0];
                6'h07: r = $unsigned($signed(b) >>> a[4:0]);
                6'h20, 6'h21: begin
                    r = a + b; trap = (fn == 6'h20);
                    ov = (a[31] == b[31]) && (r[31] != a[31]);
                end
                6'h22, 6'h23: begin
                    r = a - b; trap = (fn == 6'h22);
                    ov = (a[31] != b[31]) && (r[31] != a[31]);
                end
                6'h24: r = a & b;
                6'h25: r = a | b;
                6'h26: r = a ^ b;
                6'h27: r = ~(a | b);
                6'h2a: r = {31'd0, $signed(a) < $signed(b)};
                6'h2b: r = {31'd0, a < b};
                default: ok = 1'b0;
            endcase
        end else begin
            case (op)
                6'h08, 6'h09: begin
                    r = a + se; trap = (op == 6'h08);
                    ov = (a[31] == se[31]) && (r[31] != a[31]);
                end
                6'h0a: r = {31'd0, $signed(a) < $signed(se)};
                6'h0b: r = {31'd0, a < se};
                6'h0c: r = a & ze;
                6'h0d: r = a | ze;
                6'h0e: r = a ^ ze;
                6'h0f: r = {im, 16'd0};
                default: ok = 1'b0;
            endcase
        end
        if (!ok) return {1'b1, 1'b0, 1'b0, 32'd0};
        if (trap && ov) return {1'b0, 1'b1, 1'b0, r};
        return {1'b0, 1'b0, 1'b1, r};
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'h00) begin
            case (fn)
                6'h00, 6'h02, 6'h03: return "R4";
                6'h04, 6'h06, 6'h07: return "R5";
                6'h20, 6'h21, 6'h22, 6'h23: return "R1";
                6'h24, 6'h25, 6'h26, 6'h27: return "R2";
                6'h2a, 6'h2b: return "R6";
                default: return "R9";
            endcase
        end
        case (op)
            6'h08, 6'h09, 6'h0c, 6'h0d, 6'h0e: return "R7";
            6'h0a, 6'h0b: return "R6";
            6'h0f: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sa,
                         input logic [15:0] im, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        opcode = op; funct = fn; shamt = sa; imm = im; src_a = a; src_b = b;
        #1;
    endtask

    task automatic compare(input string tag, input logic [34:0] exp);
        logic [34:0] got;
        got = {rsvd_exc, ovf_exc, wr_en, result};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%h fn=%h: got rsvd=%b ovf=%b we=%b res=%h, exp rsvd=%b ovf=%b we=%b res=%h",
                     tag, opcode, funct, got[34], got[33], got[32], got[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic directed(input string tag, input logic [5:0] op, input logic [5:0] fn,
                            input logic [4:0] sa, input logic [15:0] im,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] exp_res, input logic exp_we,
                            input logic exp_ovf, input logic exp_rsvd);
        apply(op, fn, sa, im, a, b);
        compare(tag, {exp_rsvd, exp_ovf, exp_we, exp_res});
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom % 6)
            0: return 32'h0000_0000;
            1: return 32'h7fff_ffff;
            2: return 32'h8000_0000;
            3: return 32'hffff_ffff;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        logic [5:0] legal_fn [16];
        legal_fn = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h20, 6'h21,
                     6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2a, 6'h2b};
        void'($urandom(32'h5eed_0042));
        opcode = '0; funct = '0; shamt = '0; imm = '0; src_a = '0; src_b = '0;

        // all-zero inputs: shift left of zero, written (R4 / R10)
        directed("R10", 6'h00, 6'h00, 5'd0, 16'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        // R1 wrapping forms
        directed("R1", 6'h00, 6'h21, 5'd0, 16'h0, 32'h7fffffff, 32'h1, 32'h80000000, 1'b1, 1'b0, 1'b0);
        directed("R1", 6'h00, 6'h23, 5'd0, 16'h0, 32'h80000000, 32'h1, 32'h7fffffff, 1'b1, 1'b0, 1'b0);
        // R3 trapping forms
        directed("R3", 6'h00, 6'h20, 5'd0, 16'h0, 32'h7fffffff, 32'h1, 32'h80000000, 1'b0, 1'b1, 1'b0);
        directed("R3", 6'h00, 6'h22, 5'd0, 16'h0, 32'h80000000, 32'h1, 32'h7fffffff, 1'b0, 1'b1, 1'b0);
        directed("R3", 6'h08, 6'h00, 5'd0, 16'h0001, 32'h7fffffff, 32'h0, 32'h80000000, 1'b0, 1'b1, 1'b0);
        directed("R3", 6'h09, 6'h00, 5'd0, 16'h0001, 32'h7fffffff, 32'h0, 32'h80000000, 1'b1, 1'b0, 1'b0);
        directed("R1", 6'h00, 6'h20, 5'd0, 16'h0, 32'hfffffffe, 32'h1, 32'hffffffff, 1'b1, 1'b0, 1'b0);
        // R2 logic
        directed("R2", 6'h00, 6'h24, 5'd0, 16'h0, 32'habcd1234, 32'hffff0000, 32'habcd0000, 1'b1, 1'b0, 1'b0);
        directed("R2", 6'h00, 6'h25, 5'd0, 16'h0, 32'habcd1234, 32'hffff0000, 32'hffff1234, 1'b1, 1'b0, 1'b0);
        directed("R2", 6'h00, 6'h26, 5'd0, 16'h0, 32'habcd1234, 32'hffff0000, 32'h54321234, 1'b1, 1'b0, 1'b0);
        directed("R2", 6'h00, 6'h27, 5'd0, 16'h0, 32'habcd1234, 32'hffff0000, 32'h0000edcb, 1'b1, 1'b0, 1'b0);
        // R4 constant shifts
        directed("R4", 6'h00, 6'h00, 5'd8, 16'h0, 32'h0, 32'habcd1234, 32'hcd123400, 1'b1, 1'b0, 1'b0);
        directed("R4", 6'h00, 6'h02, 5'd10, 16'h0, 32'h0, 32'habcd1234, 32'h002af344, 1'b1, 1'b0, 1'b0);
        directed("R4", 6'h00, 6'h03, 5'd4, 16'h0, 32'h0, 32'habcd1234, 32'hfabcd123, 1'b1, 1'b0, 1'b0);
        // R5 variable shifts, upper amount bits ignored
        directed("R5", 6'h00, 6'h06, 5'd3, 16'h0, 32'h00000030, 32'habcd1234, 32'h0000abcd, 1'b1, 1'b0, 1'b0);
        directed("R5", 6'h00, 6'h07, 5'd0, 16'h0, 32'hffffffe4, 32'habcd1234, 32'hfabcd123, 1'b1, 1'b0, 1'b0);
        directed("R5", 6'h00, 6'h04, 5'd0, 16'h0, 32'h0000003f, 32'h00000001, 32'h80000000, 1'b1, 1'b0, 1'b0);
        // R6 compares
        directed("R6", 6'h00, 6'h2a, 5'd0, 16'h0, 32'h1, 32'hffffffff, 32'h0, 1'b1, 1'b0, 1'b0);
        directed("R6", 6'h00, 6'h2b, 5'd0, 16'h0, 32'h1, 32'hffffffff, 32'h1, 1'b1, 1'b0, 1'b0);
        directed("R6", 6'h0a, 6'h00, 5'd0, 16'hffff, 32'h1, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        directed("R6", 6'h0b, 6'h00, 5'd0, 16'hffff, 32'h1, 32'h0, 32'h1, 1'b1, 1'b0, 1'b0);
        // R7 extension
        directed("R7", 6'h09, 6'h00, 5'd0, 16'hffff, 32'h5, 32'h0, 32'h4, 1'b1, 1'b0, 1'b0);
        directed("R7", 6'h0c, 6'h00, 5'd0, 16'h8001, 32'hffffffff, 32'h0, 32'h00008001, 1'b1, 1'b0, 1'b0);
        directed("R7", 6'h0d, 6'h00, 5'd0, 16'h8000, 32'h0, 32'h0, 32'h00008000, 1'b1, 1'b0, 1'b0);
        directed("R7", 6'h0e, 6'h00, 5'd0, 16'hffff, 32'hffff0000, 32'h0, 32'hffffffff, 1'b1, 1'b0, 1'b0);
        // R8 load upper
        directed("R8", 6'h0f, 6'h00, 5'd0, 16'hac51, 32'hffffffff, 32'hffffffff, 32'hac510000, 1'b1, 1'b0, 1'b0);
        // R9 reserved encodings
        directed("R9", 6'h3f, 6'h20, 5'd0, 16'h1234, 32'h1, 32'h2, 32'h0, 1'b0, 1'b0, 1'b1);
        directed("R9", 6'h00, 6'h01, 5'd0, 16'h0, 32'h1, 32'h2, 32'h0, 1'b0, 1'b0, 1'b1);

        // constrained random against the model
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] op, fn;
            int sel;
            sel = $urandom % 10;
            if (sel < 6) begin
                op = 6'h00;
                fn = ($urandom % 8 == 0) ? 6'($urandom) : legal_fn[$urandom % 16];
            end else if (sel < 9) begin
                op = 6'h08 + 6'($urandom % 8);
                fn = 6'($urandom);
            end else begin
                op = 6'($urandom);
                fn = 6'($urandom);
            end
            apply(op, fn, 5'($urandom), 16'($urandom), pick_operand(), pick_operand());
            compare(req_of(op, fn), model(opcode, funct, shamt, imm, src_a, src_b));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout, exp completion");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule